// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block gives a host a small control register for sending single commands to an external three-wire serial EEPROM of up to 64 sixteen-bit words. The host writes an operation code and a 6-bit word address, and sets a go bit in the same write. The block then drives chip select, a serial clock and a serial data line, sends the command, and moves a data word out or in. After a program or erase it waits for the memory to report ready. When the command is complete it clears the go bit itself.

The serial clock comes from the system clock through a divider that the host sets at a pin. Read data is held in a 16-bit register that the host reads after the go bit has dropped. While a command is running, the control register ignores all writes.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset the control readback is all zeros and chip select is low. Readback bits 31:9 always read zero.
- R2: A write with bit 8 set while idle starts a command. Bit 8 reads 1 from the next cycle on and returns to 0 by itself once the command has finished. Chip select is high only while bit 8 reads 1.
- R3: Every command frame goes out MSB first. It is a 1 start bit, then control bits 7:6 as the opcode, then address bits 5:0. Opcode encodings: 11 erase, 10 read, 01 write, 00 enable/disable. The data line changes only while the serial clock is low and is read on its rising edge.
- R4: Opcode 00 with address bits 5:4 = 11 sends the write-enable frame. Opcode 00 with address bits 5:4 = 00 sends the write-disable frame. Each is exactly 9 bits, with no data phase and no ready polling.
- R5: A write sends the 16-bit `wr_word`, sampled at the start, MSB first, directly after the address bits.
- R6: A read clocks 16 more bits. The data line is held at 0 during those bits. The bits are taken from `ee_do` on each rising serial clock edge, MSB first, and appear on `rd_word` by the time bit 8 clears.
- R7: After a write or an erase frame, chip select drops for one serial clock period and then rises to poll `ee_do` once per half period. Polling ends at the first half period in which `ee_do` is high.
- R8: If `ee_do` stays low, polling ends after TO_TICKS half periods. Chip select is then high for exactly TO_TICKS*(sk_div+1) clock cycles.
- R9: One serial clock half period lasts sk_div+1 system clock cycles. A frame of n bits keeps chip select high for 2*n*(sk_div+1) cycles.
- R10: Between any two chip-select-high intervals, chip select stays low for at least 2*(sk_div+1) cycles. The serial clock is low whenever chip select is low.
- R11: While bit 8 reads 1, register writes are ignored. The opcode and address fields do not change, and the running frame is unaffected.
- R12: A write with bit 8 clear while idle updates the opcode and address fields and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 9 | Write value: go bit 8, opcode 7:6, word address 5:0 |
| cfg_rdata | output | 32 | Control register readback |
| wr_word | input | 16 | Data word sent by a write command |
| rd_word | output | 16 | Data word captured by the last read |
| sk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |

## Verification
The bench runs all five command types against a behavioural memory model that collects the bits on rising serial clock edges and returns read data on falling edges. Distinct data patterns (alternating, sparse, edge bits set) show that bit order and opcode placement are correct. Write and erase are run once with the ready line already high and once with it stuck low, which separates an immediate poll exit from a full timeout. The sequence is repeated at two divider settings to expose period arithmetic that only holds for one value. A register write sent in the middle of a read shows whether busy gating guards both the fields and the frame.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CMD_W   = 9;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int ADDR_W  = 6;

  typedef enum logic [1:0] {
    OP_EWX   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } eep_op_e;

  // number of serial clocks the frame occupies
  function automatic logic [4:0] frame_len(eep_op_e op);
    return (op == OP_WRITE || op == OP_READ) ? 5'(FRAME_W) : 5'(CMD_W);
  endfunction

  // full outgoing bit pattern, left aligned, MSB first on the wire
  function automatic logic [FRAME_W-1:0] build_frame(eep_op_e op,
                                                     logic [ADDR_W-1:0] addr,
                                                     logic [DATA_W-1:0] data);
    return {1'b1, op, addr, (op == OP_WRITE) ? data : {DATA_W{1'b0}}};
  endfunction

  function automatic logic needs_poll(eep_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE);
  endfunction

  function automatic logic [31:0] pack_ctrl(logic busy, eep_op_e op,
                                            logic [ADDR_W-1:0] addr);
    return {23'd0, busy, op, addr};
  endfunction
endpackage

// File: rtl/eep_sk_div.sv
module eep_sk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != '0) && $stable(div) |=> !tick); // R9
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int TO_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  eep_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick,
  output logic              run,
  output logic              done,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int TO_W = $clog2(TO_TICKS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_DESEL, S_POLL, S_GAP
  } seq_st_e;

  seq_st_e              st;
  eep_op_e              op_q;
  logic [4:0]           len_q;
  logic [4:0]           bitcnt;
  logic [FRAME_W-1:0]   shreg;
  logic                 half;
  logic [TO_W-1:0]      tocnt;

  // named internal events
  logic rise_evt, fall_evt, last_bit, frame_end, poll_exit, gap_end;

  assign rise_evt  = (st == S_SHIFT) && tick && !ee_sk;
  assign fall_evt  = (st == S_SHIFT) && tick && ee_sk;
  assign last_bit  = (bitcnt == len_q - 5'd1);
  assign frame_end = fall_evt && last_bit;
  assign poll_exit = (st == S_POLL) && tick &&
                     (ee_do || (tocnt == TO_W'(TO_TICKS - 1)));
  assign gap_end   = (st == S_GAP) && tick && half;

  assign run     = (st != S_IDLE);
  assign done    = gap_end;
  assign rd_load = frame_end && (op_q == OP_READ);
  assign ee_di   = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_EWX;
      len_q   <= 5'd0;
      bitcnt  <= 5'd0;
      shreg   <= '0;
      half    <= 1'b0;
      tocnt   <= '0;
      rd_data <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            op_q   <= op_i;
            len_q  <= frame_len(op_i);
            shreg  <= build_frame(op_i, addr_i, wdata_i);
            bitcnt <= 5'd0;
            ee_cs  <= 1'b1;
            ee_sk  <= 1'b0;
            st     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (rise_evt) begin
            ee_sk <= 1'b1;
            if (bitcnt >= 5'(CMD_W)) rd_data <= {rd_data[DATA_W-2:0], ee_do};
          end
          if (fall_evt) begin
            ee_sk <= 1'b0;
            if (last_bit) begin
              ee_cs <= 1'b0;
              half  <= 1'b0;
              st    <= needs_poll(op_q) ? S_DESEL : S_GAP;
            end else begin
              bitcnt <= bitcnt + 5'd1;
              shreg  <= shreg << 1;
            end
          end
        end
        S_DESEL: begin
          if (tick) begin
            if (half) begin
              ee_cs <= 1'b1;
              tocnt <= '0;
              st    <= S_POLL;
            end else begin
              half <= 1'b1;
            end
          end
        end
        S_POLL: begin
          if (poll_exit) begin
            ee_cs <= 1'b0;
            half  <= 1'b0;
            st    <= S_GAP;
          end else if (tick) begin
            tocnt <= tocnt + 1'b1;
          end
        end
        S_GAP: begin
          if (tick) begin
            if (half) st <= S_IDLE;
            else      half <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk); // R10
  AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ee_sk)); // R9
  AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |=> (!ee_sk || $stable(ee_di))); // R3
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (tocnt < TO_W'(TO_TICKS))); // R8
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int TO_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [8:0]       cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [15:0]      wr_word,
  output logic [15:0]      rd_word,
  input  logic [DIV_W-1:0] sk_div,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  logic              busy_q;
  eep_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, start;
  logic              seq_run, seq_done, seq_rd_load, tick;
  logic [DATA_W-1:0] seq_rd;

  assign accept = cfg_we && !busy_q;
  assign start  = accept && cfg_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= OP_EWX;
      addr_q  <= '0;
      rd_word <= '0;
    end else begin
      if (accept) begin
        op_q   <= eep_op_e'(cfg_wdata[7:6]);
        addr_q <= cfg_wdata[5:0];
      end
      if (start)         busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;
      if (seq_rd_load) rd_word <= seq_rd;
    end
  end

  assign cfg_rdata = pack_ctrl(busy_q, op_q, addr_q);

  eep_sk_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (seq_run),
    .div  (sk_div),
    .tick (tick)
  );

  eep_seq #(.TO_TICKS(TO_TICKS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_i   (eep_op_e'(cfg_wdata[7:6])),
    .addr_i (cfg_wdata[5:0]),
    .wdata_i(wr_word),
    .tick   (tick),
    .run    (seq_run),
    .done   (seq_done),
    .rd_load(seq_rd_load),
    .rd_data(seq_rd),
    .ee_cs  (ee_cs),
    .ee_sk  (ee_sk),
    .ee_di  (ee_di),
    .ee_do  (ee_do)
  );

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cfg_we |=> $stable(op_q) && $stable(addr_q)); // R11
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy_q); // R2
  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> busy_q); // R2
  AST_RD_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rd_load |-> (op_q == OP_READ)); // R6
endmodule

// File: tb/eep_cmd_ctrl_tb.sv
module eep_cmd_ctrl_tb;
  localparam int DIV_W = 8;
  localparam int TO    = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [8:0]       cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic [15:0]      wr_word = '0;
  logic [15:0]      rd_word;
  logic [DIV_W-1:0] sk_div = 8'd2;
  logic             ee_cs, ee_sk, ee_di;
  logic             ee_do = 1'b0;

  always #2 clk = ~clk;

  eep_cmd_ctrl #(.DIV_W(DIV_W), .TO_TICKS(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_word(wr_word), .rd_word(rd_word),
    .sk_div(sk_div), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int errs = 0, checks = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural memory model
  bit          bits[$];
  bit          rd_mode = 1'b0;
  logic [15:0] mem_val = '0;

  always @(posedge ee_sk) bits.push_back(ee_di);
  always @(negedge ee_sk)
    if (rd_mode && bits.size() >= 9 && bits.size() < 25)
      ee_do <= mem_val[24 - bits.size()];

  // reference register model and per-clock comparison
  bit        exp_busy = 1'b0;
  logic [7:0] exp_fields = '0;
  int  sk_hi = 0, cs_hi = 0, cs_lo = 0, first_hi = 0, last_hi = 0, cs_rises = 0;
  bit  prev_cs = 1'b0, seen_hi = 1'b0, first_taken = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cfg_rdata[31:9] == '0, "R1", "reserved bits", cfg_rdata[31:9], 0);
      chk(cfg_rdata[7:0] == exp_fields, "R11", "fields vs model", cfg_rdata[7:0], exp_fields);
      if (!ee_cs) chk(!ee_sk, "R10", "sk low while deselected", ee_sk, 0);
      if (ee_cs) chk(cfg_rdata[8], "R2", "busy while selected", cfg_rdata[8], 1);
      if (ee_sk) sk_hi++;
      else if (sk_hi > 0) begin
        chk(sk_hi == int'(sk_div) + 1, "R9", "sk high width", sk_hi, int'(sk_div) + 1);
        sk_hi = 0;
      end
      if (ee_cs) begin
        if (!prev_cs) begin
          if (seen_hi)
            chk(cs_lo >= 2 * (int'(sk_div) + 1), "R10", "cs low gap", cs_lo, 2 * (int'(sk_div) + 1));
          cs_hi = 0;
          cs_rises++;
        end
        cs_hi++;
        seen_hi = 1'b1;
      end else begin
        if (prev_cs) begin
          if (!first_taken) begin first_hi = cs_hi; first_taken = 1'b1; end
          last_hi = cs_hi;
          cs_lo = 0;
        end
        cs_lo++;
      end
      prev_cs = ee_cs;
    end
  end

  task automatic wr(logic [8:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    if (!exp_busy) begin
      exp_fields = v[7:0];
      if (v[8]) exp_busy = 1'b1;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cmd(logic [1:0] op, logic [5:0] addr, logic [15:0] wd,
                         logic [15:0] rv, bit rdy, bit poke, string req);
    bit exp_q[$];
    int cyc;
    int n;
    bits.delete();
    first_taken = 1'b0;
    rd_mode = (op == 2'b10);
    mem_val = rv;
    ee_do <= (op == 2'b10) ? 1'b0 : rdy;
    wr_word = wd;
    wr({1'b1, op, addr});
    chk(cfg_rdata[8] == 1'b1, "R2", "busy after start", cfg_rdata[8], 1);
    if (poke) begin
      wr(9'h1FF);
      chk(cfg_rdata[7:0] == {op, addr}, "R11", "fields after write while busy",
          cfg_rdata[7:0], {op, addr});
    end
    cyc = 0;
    while (cfg_rdata[8] && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cfg_rdata[8] == 1'b0, "R2", "busy self-clears", cfg_rdata[8], 0);
    exp_busy = 1'b0;
    rd_mode = 1'b0;
    exp_q.push_back(1'b1);
    for (int i = 1; i >= 0; i--) exp_q.push_back(op[i]);
    for (int i = 5; i >= 0; i--) exp_q.push_back(addr[i]);
    if (op == 2'b01) for (int i = 15; i >= 0; i--) exp_q.push_back(wd[i]);
    if (op == 2'b10) for (int i = 15; i >= 0; i--) exp_q.push_back(1'b0);
    n = exp_q.size();
    chk(bits.size() == n, req, "frame length", bits.size(), n);
    for (int i = 0; i < n && i < bits.size(); i++)
      chk(bits[i] == exp_q[i], (i < 9) ? "R3" : req, "frame bit", bits[i], exp_q[i]);
    chk(first_hi == 2 * n * (int'(sk_div) + 1), "R9", "frame cs duration",
        first_hi, 2 * n * (int'(sk_div) + 1));
    if (op == 2'b10) chk(rd_word == rv, "R6", "read word", rd_word, rv);
    if (op == 2'b01 || op == 2'b11) begin
      if (rdy) chk(last_hi == int'(sk_div) + 1, "R7", "poll ready length",
                   last_hi, int'(sk_div) + 1);
      else     chk(last_hi == TO * (int'(sk_div) + 1), "R8", "poll timeout length",
                   last_hi, TO * (int'(sk_div) + 1));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int rises;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1", "reset readback", cfg_rdata, 0);
    chk(ee_cs == 1'b0, "R1", "reset cs", ee_cs, 0);

    run_cmd(2'b00, 6'h30, 16'h0000, 16'h0000, 1'b0, 1'b0, "R4");   // enable
    run_cmd(2'b01, 6'h15, 16'hA5C3, 16'h0000, 1'b1, 1'b0, "R5");   // write, ready
    run_cmd(2'b10, 6'h2A, 16'h0000, 16'h3C96, 1'b0, 1'b1, "R6");   // read, poked R11
    run_cmd(2'b11, 6'h3F, 16'h0000, 16'h0000, 1'b0, 1'b0, "R8");   // erase, timeout
    run_cmd(2'b00, 6'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, "R4");   // disable

    // R12: fields update without a transfer
    rises = cs_rises;
    wr(9'h045);
    repeat (20) @(negedge clk);
    chk(cfg_rdata == 32'h45, "R12", "readback after plain write", cfg_rdata, 32'h45);
    chk(cs_rises == rises, "R12", "no transfer started", cs_rises, rises);

    // faster divider
    sk_div = 8'd0;
    seen_hi = 1'b0;
    run_cmd(2'b10, 6'h01, 16'h0000, 16'h8001, 1'b0, 1'b0, "R6");
    run_cmd(2'b01, 6'h3E, 16'h0001, 16'h0000, 1'b0, 1'b0, "R5");
    run_cmd(2'b11, 6'h00, 16'h0000, 16'h0000, 1'b1, 1'b0, "R7");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule